// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

The block keeps a free-running timestamp counter and copies its value into one of four capture slots whenever a chosen edge appears on a single input pin. The slots are filled in rotation. Each slot selects its own edge direction, so a sequence such as rise, fall, rise, fall can be timed with no software action between the edges. The pin passes through a two-flop synchronizer, and an optional prescaler can thin out the qualifying edges before they reach the slots.

Software drives the unit through a plain 32-bit read/write port. There are registers for the counter, the four slots, a control word, an enable/flag word and a write-one-to-clear word. Each slot load raises its own flag, and so does a counter wrap. A single interrupt line is asserted while the global flag is set and at least one enabled event flag is set. In one-shot operation the unit stops loading after a chosen slot. A re-arm strobe resets the slot pointer to slot 0 and starts loading again.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset every readable register reads 0 and `irq` is low.
- R2: The counter (offset 0x00) adds 1 on each clock while control bit 20 is set and holds otherwise. A write to 0x00 presets it, and the write takes priority over the increment.
- R3: A counter step from all-ones to 0 sets event flag 4 (enable/flag register bit 21).
- R4: While control bit 8 is set, each qualified edge stores the counter into the slot the pointer selects (slot i at offset 0x08+4*i). The pointer then moves 0,1,2,3,0. While bit 8 is clear, nothing is stored and no flag is set.
- R5: Control bit 2*i sets the edge for slot i: 1 selects the falling edge and 0 selects the rising edge. An edge of the other direction has no effect.
- R6: With a prescale value N in control bits 13:9, only every (2*N)-th qualifying edge produces a capture. N=0 passes every edge. A re-arm restarts the prescale count.
- R7: When control bit 16 is 1 (one-shot), loading stops after the slot number held in bits 18:17. Writing the control word with bit 19 set resets the pointer to 0 and re-enables loading.
- R8: A load into slot i sets flag i, which reads back at bit 17+i of the enable/flag register (offset 0x2C). Enables are written and read at bits 5:1 of the same register, and the global flag reads at bit 0.
- R9: Writing 1 to bit i+1 of the clear register (offset 0x30) clears flag i, and writing 1 to bit 0 clears the global flag. Zero bits have no effect. If an event sets a flag in the same cycle that software clears it, the flag ends up set.
- R10: `irq` is high exactly when the global flag is set and some flag with its enable set is set. The global flag is set by any enabled event.
- R11: The control word (offset 0x28) reads back the polarity, load-enable, prescale, one-shot, stop-slot and run fields as written. The re-arm bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous signal whose edges are timestamped |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the rules that depend only on local state. Loads never happen with load-enable clear. The pointer steps by one per load, holds otherwise and returns to 0 on a re-arm. A stopped counter does not move, a wrap always raises the overflow flag, `irq` never rises without the global flag, and at most one slot flag is set per cycle. The bench scenarios are needed for the rest: the exact stored timestamps, the polarity filtering, the prescale ratio, the one-shot stop and resume, the same-cycle set-versus-clear case, and the register readback.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int NUM_EVT   = NUM_SLOTS + 1;
  localparam int PS_W      = 5;

  // register offsets (bytes)
  localparam logic [7:0] OFF_CNT   = 8'h00;
  localparam logic [7:0] OFF_SLOT0 = 8'h08;
  localparam logic [7:0] OFF_CTRL  = 8'h28;
  localparam logic [7:0] OFF_ENFL  = 8'h2C;
  localparam logic [7:0] OFF_CLR   = 8'h30;

  // control word bit positions
  localparam int B_LOAD  = 8;
  localparam int B_PS_LO = 9;
  localparam int B_ONE   = 16;
  localparam int B_STOP  = 17;
  localparam int B_REARM = 19;
  localparam int B_RUN   = 20;
  localparam int B_EN_LO = 1;
  localparam int B_FL_LO = 17;

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] p);
    return SLOT_W'(p + 1'b1);
  endfunction

  // true when the current qualifying edge is the one the prescaler lets through
  function automatic logic ps_pass(input logic [PS_W:0] cnt, input logic [PS_W-1:0] n);
    if (n == '0) return 1'b1;
    return cnt == (PS_W+1)'({n, 1'b0} - 1'b1);
  endfunction

  function automatic logic irq_of(input logic g, input logic [NUM_EVT-1:0] fl,
                                  input logic [NUM_EVT-1:0] en);
    return g & (|(fl & en));
  endfunction
endpackage

// File: rtl/esc_edge_qual.sv
module esc_edge_qual
  import esc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin,
  input  logic            pol_fall,
  input  logic [PS_W-1:0] ps_n,
  input  logic            restart,
  output logic            evt
);
  logic s1_q, s2_q, prev_q;
  logic [PS_W:0] ps_cnt_q;
  logic qual, pass;

  assign qual = (s2_q != prev_q) && (s2_q != pol_fall);
  assign pass = ps_pass(ps_cnt_q, ps_n);
  assign evt  = qual && pass && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      prev_q   <= 1'b0;
      ps_cnt_q <= '0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (restart)      ps_cnt_q <= '0;
      else if (qual)    ps_cnt_q <= pass ? '0 : ps_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/esc_slot_seq.sv
module esc_slot_seq
  import esc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              load_en,
  input  logic              one_shot,
  input  logic [SLOT_W-1:0] stop_slot,
  input  logic              rearm,
  output logic              load,
  output logic [SLOT_W-1:0] ptr
);
  logic done_q;

  assign load = evt && load_en && !(one_shot && done_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      done_q <= 1'b0;
    end else if (rearm) begin
      ptr    <= '0;
      done_q <= 1'b0;
    end else if (load) begin
      ptr <= next_slot(ptr);
      if (one_shot && ptr == stop_slot) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/esc_irq_unit.sv
module esc_irq_unit
  import esc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_vec,
  input  logic [NUM_EVT-1:0] en,
  input  logic               clr_wr,
  input  logic [NUM_EVT:0]   clr_bits,
  output logic [NUM_EVT-1:0] flags,
  output logic               gflag,
  output logic               irq
);
  logic [NUM_EVT-1:0] clr_f;
  logic               clr_g;

  assign clr_f = clr_wr ? clr_bits[NUM_EVT:1] : '0;
  assign clr_g = clr_wr & clr_bits[0];
  assign irq   = irq_of(gflag, flags, en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      gflag <= 1'b0;
    end else begin
      flags <= (flags & ~clr_f) | set_vec;          // set wins
      gflag <= (gflag & ~clr_g) | (|(set_vec & en));
    end
  end
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
  import esc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_pin,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  // control fields
  logic [NUM_SLOTS-1:0] pol_q;
  logic                 load_en_q, one_q, run_q;
  logic [PS_W-1:0]      ps_q;
  logic [SLOT_W-1:0]    stop_q;
  logic [NUM_EVT-1:0]   en_q;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] slot_q [NUM_SLOTS];

  // named internal events
  logic wr_cnt, wr_ctrl, wr_enfl, wr_clr, rearm;
  logic evt, load, ovf_evt, gflag;
  logic [SLOT_W-1:0]  ptr;
  logic [NUM_EVT-1:0] set_vec, flags;
  logic [31:0] ctrl_rd;

  assign wr_cnt  = bus_we && bus_addr == ADDR_W'(OFF_CNT);
  assign wr_ctrl = bus_we && bus_addr == ADDR_W'(OFF_CTRL);
  assign wr_enfl = bus_we && bus_addr == ADDR_W'(OFF_ENFL);
  assign wr_clr  = bus_we && bus_addr == ADDR_W'(OFF_CLR);
  assign rearm   = wr_ctrl && bus_wdata[B_REARM];
  assign ovf_evt = run_q && !wr_cnt && (cnt_q == '1);

  esc_edge_qual u_qual (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .pol_fall(pol_q[ptr]),
    .ps_n(ps_q), .restart(rearm), .evt(evt));

  esc_slot_seq u_seq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .load_en(load_en_q),
    .one_shot(one_q), .stop_slot(stop_q), .rearm(rearm),
    .load(load), .ptr(ptr));

  always_comb begin
    set_vec = '0;
    set_vec[NUM_EVT-1] = ovf_evt;
    if (load) set_vec[ptr] = 1'b1;
  end

  esc_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .en(en_q),
    .clr_wr(wr_clr), .clr_bits(bus_wdata[NUM_EVT:0]),
    .flags(flags), .gflag(gflag), .irq(irq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0; load_en_q <= 1'b0; one_q <= 1'b0; run_q <= 1'b0;
      ps_q <= '0; stop_q <= '0; en_q <= '0;
    end else begin
      if (wr_ctrl) begin
        for (int i = 0; i < NUM_SLOTS; i++) pol_q[i] <= bus_wdata[2*i];
        load_en_q <= bus_wdata[B_LOAD];
        ps_q      <= bus_wdata[B_PS_LO +: PS_W];
        one_q     <= bus_wdata[B_ONE];
        stop_q    <= bus_wdata[B_STOP +: SLOT_W];
        run_q     <= bus_wdata[B_RUN];
      end
      if (wr_enfl) en_q <= bus_wdata[B_EN_LO +: NUM_EVT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= bus_wdata[CNT_W-1:0];
    else if (run_q)  cnt_q <= cnt_q + 1'b1;
  end

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       slot_q[g] <= '0;
        else if (load && ptr == SLOT_W'(g)) slot_q[g] <= cnt_q;
      end
    end
  endgenerate

  always_comb begin
    ctrl_rd = '0;
    for (int i = 0; i < NUM_SLOTS; i++) ctrl_rd[2*i] = pol_q[i];
    ctrl_rd[B_LOAD]             = load_en_q;
    ctrl_rd[B_PS_LO +: PS_W]    = ps_q;
    ctrl_rd[B_ONE]              = one_q;
    ctrl_rd[B_STOP +: SLOT_W]   = stop_q;
    ctrl_rd[B_RUN]              = run_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CNT)) bus_rdata = 32'(cnt_q);
    else if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = ctrl_rd;
    else if (bus_addr == ADDR_W'(OFF_ENFL)) begin
      bus_rdata[0]                 = gflag;
      bus_rdata[B_EN_LO +: NUM_EVT] = en_q;
      bus_rdata[B_FL_LO +: NUM_EVT] = flags;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++)
        if (bus_addr == ADDR_W'(OFF_SLOT0 + 8'(4*i))) bus_rdata = 32'(slot_q[i]);
    end
  end
endmodule

// File: rtl/esc_checker.sv
module esc_checker
  import esc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load,
  input logic               load_en,
  input logic               rearm,
  input logic [SLOT_W-1:0]  ptr,
  input logic               run,
  input logic               cnt_wr,
  input logic [CNT_W-1:0]   cnt,
  input logic               ovf_evt,
  input logic [NUM_EVT-1:0] flags,
  input logic [NUM_EVT-1:0] set_vec,
  input logic               gflag,
  input logic               irq
);
  p_no_load_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |-> !load);
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load && !rearm |=> ptr == SLOT_W'($past(ptr) + 1'b1));
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !rearm |=> $stable(ptr));
  p_rearm_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> ptr == '0);
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr |=> $stable(cnt));
  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[NUM_EVT-1]);
  p_irq_global_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gflag);
  p_one_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec[NUM_SLOTS-1:0]));
endmodule

bind edge_stamp_capture esc_checker #(.CNT_W(CNT_W)) u_esc_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .load_en(load_en_q), .rearm(rearm),
  .ptr(ptr), .run(run_q), .cnt_wr(wr_cnt), .cnt(cnt_q), .ovf_evt(ovf_evt),
  .flags(flags), .set_vec(set_vec), .gflag(gflag), .irq(irq));

// File: tb/test_edge_stamp_capture.sv
module test_edge_stamp_capture;
  localparam logic [31:0] LEN = 32'h100, RUN = 32'h10_0000, ONE = 32'h1_0000,
                          RA = 32'h8_0000;
  logic clk = 0, rst_n = 0, cap_pin = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int checks = 0, failures = 0;

  typedef struct { logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  event sample_ev;

  edge_stamp_capture i_edge_stamp_capture (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;

  function automatic logic [31:0] ps(input int n);  return 32'(n) << 9;  endfunction
  function automatic logic [31:0] stp(input int s); return 32'(s) << 17; endfunction
  function automatic logic [31:0] enfl(input logic g, input logic [4:0] en,
                                       input logic [4:0] fl);
    return (32'(fl) << 17) | (32'(en) << 1) | 32'(g);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard head
  always @(sample_ev) begin
    sb_item_t it;
    it = sb_q.pop_front();
    check(bus_rdata, it.exp, it.tag);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a;
    sb_q.push_back('{exp, tag});
    #2 -> sample_ev;
    #1;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk); check(32'(irq), 32'(exp), tag);
  endtask

  task automatic pin(input logic v);
    @(negedge clk); cap_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_at(input logic [31:0] c);
    wr(8'h00, c); pin(1); pin(0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    // R1 reset state
    rd(8'h00, 0, "R1 counter");
    rd(8'h28, 0, "R1 control");
    rd(8'h08, 0, "R1 slot0");
    rd(8'h2C, 0, "R1 enflag");
    chk_irq(0, "R1 irq");

    // R4 rotation with stopped counter, R8 flags, R10 irq
    wr(8'h28, LEN);
    wr(8'h2C, 32'h3E);
    pulse_at(100); pulse_at(200); pulse_at(300); pulse_at(400); pulse_at(500);
    rd(8'h08, 500, "R4 slot0 wrapped");
    rd(8'h0C, 200, "R4 slot1");
    rd(8'h10, 300, "R4 slot2");
    rd(8'h14, 400, "R4 slot3");
    rd(8'h2C, enfl(1, 5'h1F, 5'h0F), "R8 flags after four slots");
    chk_irq(1, "R10 irq set");

    // R9 clears
    wr(8'h30, 0);
    rd(8'h2C, enfl(1, 5'h1F, 5'h0F), "R9 zero write ignored");
    wr(8'h30, 32'h2);
    rd(8'h2C, enfl(1, 5'h1F, 5'h0E), "R9 clear flag0");
    wr(8'h30, 32'h1);
    rd(8'h2C, enfl(0, 5'h1F, 5'h0E), "R9 clear global");
    chk_irq(0, "R10 irq needs global flag");
    wr(8'h30, 32'h3F);

    // R4 load disabled
    wr(8'h28, 0);
    pulse_at(999);
    rd(8'h0C, 200, "R4 no load when disabled");
    rd(8'h2C, enfl(0, 5'h1F, 0), "R4 no flag when disabled");

    // R5 polarity: slot0 falling
    wr(8'h28, LEN | 32'h1 | RA);
    wr(8'h00, 7);
    pin(1);
    rd(8'h2C, enfl(0, 5'h1F, 0), "R5 rising ignored on falling slot");
    pin(0);
    rd(8'h08, 7, "R5 falling captured");
    rd(8'h2C, enfl(1, 5'h1F, 5'h01), "R5 flag0");
    wr(8'h30, 32'h3F);

    // R6 prescale N=1
    wr(8'h28, LEN | ps(1) | RA);
    pulse_at(40);
    rd(8'h2C, enfl(0, 5'h1F, 0), "R6 first edge held back");
    pulse_at(41);
    rd(8'h08, 41, "R6 second edge captured");
    wr(8'h30, 32'h3F);

    // R7 one-shot stopping after slot 1, then re-arm
    wr(8'h28, LEN | ONE | stp(1) | RA);
    pulse_at(60); pulse_at(61); pulse_at(62);
    rd(8'h08, 60, "R7 slot0");
    rd(8'h0C, 61, "R7 slot1");
    rd(8'h10, 300, "R7 slot2 untouched after stop");
    rd(8'h2C, enfl(1, 5'h1F, 5'h03), "R7 flags");
    wr(8'h28, LEN | ONE | stp(1) | RA);
    pulse_at(63);
    rd(8'h08, 63, "R7 re-arm resumes at slot0");
    wr(8'h30, 32'h3F);

    // R9 set wins over a same-cycle clear
    wr(8'h28, LEN | RA);
    @(negedge clk); cap_pin = 1;
    @(posedge clk); @(posedge clk);
    wr(8'h30, 32'h2);
    rd(8'h2C, enfl(1, 5'h1F, 5'h01), "R9 set wins");
    pin(0);
    wr(8'h30, 32'h3F);

    // R11 control readback
    wr(8'h28, LEN | ONE | stp(2) | ps(3) | 32'h55 | RA);
    rd(8'h28, 32'h0005_0755, "R11 control readback");

    // R2 counter runs M cycles
    wr(8'h28, 0);
    wr(8'h00, 10);
    wr(8'h28, RUN);
    repeat (9) @(posedge clk);
    wr(8'h28, 0);
    rd(8'h00, 20, "R2 counter advanced 10");
    repeat (3) @(negedge clk);
    rd(8'h00, 20, "R2 counter holds when stopped");

    // R3 overflow
    wr(8'h00, 32'hFFFF_FFFE);
    wr(8'h28, RUN);
    repeat (3) @(posedge clk);
    wr(8'h28, 0);
    rd(8'h00, 2, "R3 counter wrapped");
    rd(8'h2C, enfl(1, 5'h1F, 5'h10), "R3 overflow flag");
    chk_irq(1, "R3 overflow irq");
    wr(8'h2C, 0);
    rd(8'h2C, enfl(1, 0, 5'h10), "R10 enables cleared");
    chk_irq(0, "R10 irq masked by enables");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule